// File: doc/BRIEF.md
# Supervisory Interrupt Clock-Stop Controller

This block sits in a processor's maintenance logic and answers supervisory interrupt requests. Each request freezes the gated processor clocks. An error interrupt is a parity check that is seen while the program-status mask bit is set. A normal interrupt is a manual or test request. For these two kinds the block also moves the processor into a new control mode. A clock interrupt, caused by a storage holdoff or a single-cycle step, only freezes the clocks and leaves the control mode as it was.

Detection happens in one cycle. In that cycle the block raises the three clock-stop flags and the interrupt flag for the kind it saw, and it latches the requested mode. At the start of the next cycle, which is the first cycle with the clocks stopped, the latched request is copied into the control-mode register. All flags stay set until a synchronous restart clears them. The restart does not change the control mode.

Top module: `sic_clkstop_ctrl`

## Requirements
- R1: After reset, all three clock-stop flags, both interrupt flags and the 4-bit control mode are 0.
- R2: A parity check sampled while the mask bit is 1 sets all three clock-stop flags and the error flag at the next clock edge.
- R3: A parity check sampled while the mask bit is 0 is ignored. No flag changes and the control mode stays the same.
- R4: A request on any bit of the normal request bus sets all three clock-stop flags and the normal flag at the next clock edge. The bits are [0] system reset, [1] test load, [2] storage test and [3] mode change.
- R5: For an error or normal interrupt, the control mode takes the matching requested-mode vector one edge after the flags rise, and not on the same edge.
- R6: A request on either bit of the clock request bus ([0] storage holdoff, [1] single-cycle) sets all three clock-stop flags. It raises neither interrupt flag and leaves the control mode unchanged.
- R7: When an error interrupt and a normal interrupt are detected in the same cycle, both interrupt flags rise and the control mode takes the error-mode vector.
- R8: Restart clears all clock-stop flags and both interrupt flags at the next edge and keeps the control mode. Any request sampled in the same cycle as the restart is dropped.
- R9: Clock-stop flags and interrupt flags stay set while no restart arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Synchronous restart that clears the flags |
| parity_chk_i | input | 1 | Parity check detected |
| psw_mask_i | input | 1 | Program-status mask bit that enables error interrupts |
| norm_req_i | input | 4 | Normal requests: [0] system reset, [1] test load, [2] storage test, [3] mode change |
| clk_req_i | input | 2 | Clock-only requests: [0] storage holdoff, [1] single-cycle |
| err_mode_i | input | 4 | Mode requested on an error interrupt |
| norm_mode_i | input | 4 | Mode requested on a normal interrupt |
| stop_o | output | 3 | Clock-stop flags |
| err_int_o | output | 1 | Error interrupt flag |
| norm_int_o | output | 1 | Normal interrupt flag |
| mode_o | output | 4 | Current control mode |

## Verification
The mode-transfer properties look back two cycles at the requested-mode vectors. They therefore assume that the vectors sampled in the detection cycle are the ones meant, and they do not require the vectors to stay stable afterwards. The mode-hold property for clock interrupts applies only when no error or normal request is present in the same cycle, because an interrupt that changes the mode would override it. The directed tasks change inputs only on falling edges and hold each request for exactly one cycle. They also insert a restart between scenarios, so every property starts from a known flag state.

// File: rtl/sic_pkg.sv
package sic_pkg;
  typedef enum logic [1:0] {
    IK_NONE   = 2'd0,
    IK_CLOCK  = 2'd1,
    IK_NORMAL = 2'd2,
    IK_ERROR  = 2'd3
  } int_kind_e;

  typedef struct packed {
    logic err;
    logic norm;
    logic clk;
  } int_hits_t;
endpackage

// File: rtl/sic_classify.sv
module sic_classify
  import sic_pkg::*;
#(
  parameter int N_NORM = 4,
  parameter int N_CLK  = 2
) (
  input  logic              parity_chk_i,
  input  logic              psw_mask_i,
  input  logic [N_NORM-1:0] norm_req_i,
  input  logic [N_CLK-1:0]  clk_req_i,
  output int_hits_t         hits_o,
  output int_kind_e         kind_o
);
  always_comb begin
    hits_o.err  = parity_chk_i & psw_mask_i;
    hits_o.norm = |norm_req_i;
    hits_o.clk  = |clk_req_i;
    if (hits_o.err)       kind_o = IK_ERROR;
    else if (hits_o.norm) kind_o = IK_NORMAL;
    else if (hits_o.clk)  kind_o = IK_CLOCK;
    else                  kind_o = IK_NONE;
  end
endmodule

// File: rtl/sic_flag_bank.sv
module sic_flag_bank #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst || clr_i)   q <= 1'b0;
      else if (set_i[g])  q <= 1'b1;
    end
    assign q_o[g] = q;
  end
endmodule

// File: rtl/sic_mode_xfer.sv
module sic_mode_xfer #(
  parameter int              MODE_W   = 4,
  parameter logic [MODE_W-1:0] RST_MODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              sel_err_i,
  input  logic [MODE_W-1:0] err_mode_i,
  input  logic [MODE_W-1:0] norm_mode_i,
  output logic [MODE_W-1:0] mode_o
);
  logic [MODE_W-1:0] req_q;
  logic              pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      pend_q <= 1'b0;
      mode_o <= RST_MODE;
    end else begin
      pend_q <= load_i;
      if (load_i) req_q <= sel_err_i ? err_mode_i : norm_mode_i;
      if (pend_q) mode_o <= req_q;
    end
  end
endmodule

// File: rtl/sic_clkstop_ctrl.sv
module sic_clkstop_ctrl
  import sic_pkg::*;
#(
  parameter int N_STOP = 3,
  parameter int N_NORM = 4,
  parameter int N_CLK  = 2,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic              parity_chk_i,
  input  logic              psw_mask_i,
  input  logic [N_NORM-1:0] norm_req_i,
  input  logic [N_CLK-1:0]  clk_req_i,
  input  logic [MODE_W-1:0] err_mode_i,
  input  logic [MODE_W-1:0] norm_mode_i,
  output logic [N_STOP-1:0] stop_o,
  output logic              err_int_o,
  output logic              norm_int_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam int N_INT = 2;

  int_hits_t  hits;
  int_kind_e  kind;
  logic       accept;
  logic [N_INT-1:0] int_set;
  logic [N_INT-1:0] int_q;

  sic_classify #(.N_NORM(N_NORM), .N_CLK(N_CLK)) u_cls (
    .parity_chk_i(parity_chk_i),
    .psw_mask_i  (psw_mask_i),
    .norm_req_i  (norm_req_i),
    .clk_req_i   (clk_req_i),
    .hits_o      (hits),
    .kind_o      (kind)
  );

  assign accept  = (kind != IK_NONE) && !restart_i;
  assign int_set = {hits.err, hits.norm} & {N_INT{!restart_i}};

  sic_flag_bank #(.W(N_STOP)) u_stop (
    .clk  (clk),
    .rst  (rst),
    .clr_i(restart_i),
    .set_i({N_STOP{accept}}),
    .q_o  (stop_o)
  );

  sic_flag_bank #(.W(N_INT)) u_int (
    .clk  (clk),
    .rst  (rst),
    .clr_i(restart_i),
    .set_i(int_set),
    .q_o  (int_q)
  );

  assign err_int_o  = int_q[1];
  assign norm_int_o = int_q[0];

  sic_mode_xfer #(.MODE_W(MODE_W)) u_mode (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept && (kind == IK_ERROR || kind == IK_NORMAL)),
    .sel_err_i  (kind == IK_ERROR),
    .err_mode_i (err_mode_i),
    .norm_mode_i(norm_mode_i),
    .mode_o     (mode_o)
  );
endmodule

// File: rtl/sic_clkstop_chk.sv
module sic_clkstop_chk #(
  parameter int N_STOP = 3,
  parameter int N_NORM = 4,
  parameter int N_CLK  = 2,
  parameter int MODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              restart_i,
  input logic              parity_chk_i,
  input logic              psw_mask_i,
  input logic [N_NORM-1:0] norm_req_i,
  input logic [N_CLK-1:0]  clk_req_i,
  input logic [MODE_W-1:0] err_mode_i,
  input logic [MODE_W-1:0] norm_mode_i,
  input logic [N_STOP-1:0] stop_o,
  input logic              err_int_o,
  input logic              norm_int_o,
  input logic [MODE_W-1:0] mode_o
);
  logic e_hit, n_hit, c_hit;
  assign e_hit = parity_chk_i && psw_mask_i;
  assign n_hit = |norm_req_i;
  assign c_hit = |clk_req_i;

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
    (e_hit && !restart_i) |=> (&stop_o && err_int_o)); // R2
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (parity_chk_i && !psw_mask_i && !n_hit && !c_hit && !restart_i)
      |=> ($stable(stop_o) && $stable(err_int_o) && $stable(norm_int_o))); // R3
  AST_NORM_STOPS: assert property (@(posedge clk) disable iff (rst)
    (n_hit && !restart_i) |=> (&stop_o && norm_int_o)); // R4
  AST_NORM_MODE: assert property (@(posedge clk) disable iff (rst)
    (n_hit && !e_hit && !restart_i) |=> ##1 (mode_o == $past(norm_mode_i, 2))); // R5
  AST_ERR_MODE: assert property (@(posedge clk) disable iff (rst)
    (e_hit && !restart_i) |=> ##1 (mode_o == $past(err_mode_i, 2))); // R7
  AST_CLK_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
    (c_hit && !e_hit && !n_hit && !restart_i)
      |=> (&stop_o && $stable(mode_o) && $stable(err_int_o) && $stable(norm_int_o))); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (stop_o == '0 && !err_int_o && !norm_int_o && $stable(mode_o))); // R8
  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (&stop_o && !restart_i) |=> &stop_o); // R9
endmodule

bind sic_clkstop_ctrl sic_clkstop_chk #(
  .N_STOP(N_STOP), .N_NORM(N_NORM), .N_CLK(N_CLK), .MODE_W(MODE_W)
) u_chk (.*);

// File: tb/sic_clkstop_ctrl_test.sv
module sic_clkstop_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       restart_i = 1'b0;
  logic       parity_chk_i = 1'b0;
  logic       psw_mask_i = 1'b0;
  logic [3:0] norm_req_i = '0;
  logic [1:0] clk_req_i = '0;
  logic [3:0] err_mode_i = '0;
  logic [3:0] norm_mode_i = '0;
  logic [2:0] stop_o;
  logic       err_int_o, norm_int_o;
  logic [3:0] mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sic_clkstop_ctrl uut (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    parity_chk_i = 1'b0; psw_mask_i = 1'b0; norm_req_i = '0; clk_req_i = '0;
    restart_i = 1'b0;
  endtask

  task automatic do_restart();
    @(negedge clk) restart_i = 1'b1;
    @(negedge clk) restart_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 stop", 32'(stop_o), 0);
    chk("R1 err", 32'(err_int_o), 0);
    chk("R1 norm", 32'(norm_int_o), 0);
    chk("R1 mode", 32'(mode_o), 0);
  endtask

  task automatic t_error();
    @(negedge clk) begin parity_chk_i = 1'b1; psw_mask_i = 1'b1; err_mode_i = 4'h5; end
    @(negedge clk) idle_inputs();
    chk("R2 stop", 32'(stop_o), 7);
    chk("R2 err", 32'(err_int_o), 1);
    chk("R2 norm", 32'(norm_int_o), 0);
    chk("R5 mode not yet", 32'(mode_o), 0);
    @(negedge clk);
    chk("R5 mode err", 32'(mode_o), 5);
    repeat (5) @(negedge clk);
    chk("R9 sticky stop", 32'(stop_o), 7);
    chk("R9 sticky err", 32'(err_int_o), 1);
    do_restart();
    chk("R8 stop cleared", 32'(stop_o), 0);
    chk("R8 err cleared", 32'(err_int_o), 0);
    chk("R8 mode kept", 32'(mode_o), 5);
  endtask

  task automatic t_masked();
    @(negedge clk) begin parity_chk_i = 1'b1; psw_mask_i = 1'b0; err_mode_i = 4'hA; end
    @(negedge clk) idle_inputs();
    chk("R3 stop", 32'(stop_o), 0);
    chk("R3 err", 32'(err_int_o), 0);
    @(negedge clk);
    chk("R3 mode", 32'(mode_o), 5);
  endtask

  task automatic t_normal();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) begin norm_req_i = 4'(1 << i); norm_mode_i = 4'(8 + i); end
      @(negedge clk) idle_inputs();
      chk("R4 stop", 32'(stop_o), 7);
      chk("R4 norm", 32'(norm_int_o), 1);
      chk("R4 err", 32'(err_int_o), 0);
      @(negedge clk);
      chk("R5 mode norm", 32'(mode_o), 32'(8 + i));
      do_restart();
    end
  endtask

  task automatic t_clock();
    for (int i = 0; i < 2; i++) begin
      @(negedge clk) begin clk_req_i = 2'(1 << i); norm_mode_i = 4'h1; err_mode_i = 4'h2; end
      @(negedge clk) idle_inputs();
      chk("R6 stop", 32'(stop_o), 7);
      chk("R6 err", 32'(err_int_o), 0);
      chk("R6 norm", 32'(norm_int_o), 0);
      @(negedge clk);
      chk("R6 mode", 32'(mode_o), 11);
      do_restart();
    end
  endtask

  task automatic t_priority();
    @(negedge clk) begin
      parity_chk_i = 1'b1; psw_mask_i = 1'b1; norm_req_i = 4'b0010;
      err_mode_i = 4'h3; norm_mode_i = 4'hC;
    end
    @(negedge clk) idle_inputs();
    chk("R7 err", 32'(err_int_o), 1);
    chk("R7 norm", 32'(norm_int_o), 1);
    @(negedge clk);
    chk("R7 mode", 32'(mode_o), 3);
    do_restart();
  endtask

  task automatic t_restart_wins();
    @(negedge clk) begin
      restart_i = 1'b1; parity_chk_i = 1'b1; psw_mask_i = 1'b1; err_mode_i = 4'h9;
    end
    @(negedge clk) idle_inputs();
    chk("R8 drop stop", 32'(stop_o), 0);
    chk("R8 drop err", 32'(err_int_o), 0);
    @(negedge clk);
    chk("R8 drop mode", 32'(mode_o), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_error();
    t_masked();
    t_normal();
    t_clock();
    t_priority();
    t_restart_wins();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule